// File: doc/BRIEF.md
# Mains Cycle Period Capture

The block times the period of a mains voltage waveform that reaches it as a digital square wave from an external comparator. A local time counter runs without stopping on the tick clock. Its low bits act as the tick counter for period measurement. Each rising edge of the square wave closes one mains cycle. The block then reports the length of that cycle as a signed offset from the nominal cycle count. With the default 8.4 MHz tick clock and a 50 Hz grid, the nominal count is 168,000 ticks. Reporting only the offset keeps each measurement in a compact word, by default 16 bits.

Every accepted edge also produces a one-cycle zero-crossing strobe. On the same edge the block latches the full local time, so a host can tag each measurement with a timestamp. The square wave is asynchronous to the tick clock. It passes through a two-flop synchronizer and a rising-edge detector before any use. The first edge after reset only sets the start point of the first cycle. An offset that does not fit the output word is clamped to the nearest limit and flagged. This happens after a missed edge or a glitch.

Top module: `acl_capture`

## Requirements
- R1: While reset is asserted and until the first strobe, `cycle_o`, `ts_o`, `valid_o`, `zc_o`, `err_hi_o` and `err_lo_o` are all zero.
- R2: A rising edge on `wave_i` produces exactly one single-cycle `zc_o` pulse. If `wave_i` first reads high at clock edge k, the pulse is visible after edge k+2.
- R3: The first rising edge after reset raises `zc_o` but not `valid_o`. Every later rising edge raises `valid_o` together with `zc_o`.
- R4: With `valid_o` high, `cycle_o` is the two's-complement value, OUT_W bits wide, of (ticks between this rising edge and the previous one) minus NOMINAL. Both flags are low.
- R5: An offset above 2^(OUT_W-1)-1 gives `cycle_o` = 2^(OUT_W-1)-1, the pattern 0 followed by all ones. It sets `err_hi_o` and clears `err_lo_o`.
- R6: An offset below -2^(OUT_W-1) gives `cycle_o` = -2^(OUT_W-1), the pattern 1 followed by all zeros. It sets `err_lo_o` and clears `err_hi_o`. Offsets equal to either limit are exact and raise no flag.
- R7: Tick arithmetic is modulo 2^CNT_W. A cycle during which the tick counter wraps is still measured correctly, as long as the cycle is shorter than 2^CNT_W ticks.
- R8: `ts_o` equals the number of clock edges since reset release, taken in the cycle the rising edge was detected. This is 2 more than the count when `wave_i` was first sampled high. Consecutive timestamps therefore differ by exactly the cycle length.
- R9: Between strobes, `cycle_o`, both flags and `ts_o` hold their last values.
- R10: Falling edges and long steady levels on `wave_i` produce no strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Tick clock (nominally 8.4 MHz) |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wave_i | input | 1 | Asynchronous square wave from the mains comparator |
| cycle_o | output | OUT_W | Signed cycle-length offset from NOMINAL, in ticks |
| valid_o | output | 1 | One-cycle pulse: `cycle_o` holds a new measurement |
| zc_o | output | 1 | One-cycle pulse on every detected rising edge |
| ts_o | output | TS_W | Local time latched on the detected edge |
| err_hi_o | output | 1 | Last measurement was clamped at the positive limit |
| err_lo_o | output | 1 | Last measurement was clamped at the negative limit |

## Verification
The checker watches several properties on every cycle: the strobe stays one cycle wide, `valid_o` never appears without `zc_o`, each raised flag matches its clamped output value, the two flags never rise together, outputs hold between strobes, and timestamps increase. What only the bench scenarios can show is the value of each measurement. This covers exact offsets on both sides of nominal, both clamp boundaries and one tick past each, and a missed edge. It also covers a cycle that spans a wrap of the tick counter, the exact timestamp against an independent edge count, the two-edge latency, and the priming edge after each reset.

// File: rtl/acl_pkg.sv
package acl_pkg;
  typedef enum logic [1:0] {
    SAT_NONE = 2'b00,
    SAT_HI   = 2'b01,
    SAT_LO   = 2'b10
  } sat_e;
endpackage

// File: rtl/acl_sync_edge.sv
module acl_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES-1:0] chain_q;
  logic              last_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q[g] <= 1'b0;
        else if (g == 0) chain_q[g] <= async_i;
        else chain_q[g] <= chain_q[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) last_q <= 1'b0;
    else last_q <= chain_q[STAGES-1];
  end

  assign rise_o = chain_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/acl_time_base.sv
module acl_time_base #(
  parameter int TS_W  = 64,
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [TS_W-1:0]  time_o,
  output logic [CNT_W-1:0] tick_o
);
  logic [TS_W-1:0] time_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) time_q <= '0;
    else time_q <= time_q + 1'b1;
  end

  assign time_o = time_q;
  // tick counter is the low slice of local time: same rate, modulo 2^CNT_W
  assign tick_o = time_q[CNT_W-1:0];
endmodule

// File: rtl/acl_period_calc.sv
module acl_period_calc
  import acl_pkg::*;
#(
  parameter int CNT_W   = 32,
  parameter int OUT_W   = 16,
  parameter int NOMINAL = 168000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rise_i,
  input  logic [CNT_W-1:0] tick_i,
  output logic             primed_o,
  output logic [OUT_W-1:0] res_o,
  output sat_e             sat_o
);
  localparam int RW = CNT_W + 1;
  localparam logic [CNT_W-1:0]     NOM_C = CNT_W'(NOMINAL);
  localparam logic signed [RW-1:0] MAX_C = RW'((2 ** (OUT_W-1)) - 1);
  localparam logic signed [RW-1:0] MIN_C = ~MAX_C;

  logic [CNT_W-1:0]     prev_q;
  logic                 primed_q;
  logic [CNT_W-1:0]     diff;
  logic signed [RW-1:0] res;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q   <= '0;
      primed_q <= 1'b0;
    end else if (rise_i) begin
      prev_q   <= tick_i;
      primed_q <= 1'b1;
    end
  end

  always_comb begin
    diff = tick_i - prev_q;
    res  = $signed({1'b0, diff}) - $signed({1'b0, NOM_C});
    if (res > MAX_C) begin
      res_o = MAX_C[OUT_W-1:0];
      sat_o = SAT_HI;
    end else if (res < MIN_C) begin
      res_o = MIN_C[OUT_W-1:0];
      sat_o = SAT_LO;
    end else begin
      res_o = res[OUT_W-1:0];
      sat_o = SAT_NONE;
    end
  end

  assign primed_o = primed_q;
endmodule

// File: rtl/acl_capture.sv
module acl_capture
  import acl_pkg::*;
#(
  parameter int CNT_W   = 32,
  parameter int OUT_W   = 16,
  parameter int TS_W    = 64,
  parameter int NOMINAL = 168000,
  parameter int SYNC_N  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wave_i,
  output logic [OUT_W-1:0] cycle_o,
  output logic             valid_o,
  output logic             zc_o,
  output logic [TS_W-1:0]  ts_o,
  output logic             err_hi_o,
  output logic             err_lo_o
);
  logic             rise;
  logic [TS_W-1:0]  now;
  logic [CNT_W-1:0] tick;
  logic             primed;
  logic [OUT_W-1:0] res;
  sat_e             sat;

  acl_sync_edge #(.STAGES(SYNC_N)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .async_i(wave_i), .rise_o(rise)
  );

  acl_time_base #(.TS_W(TS_W), .CNT_W(CNT_W)) u_time (
    .clk_i(clk_i), .rst_ni(rst_ni), .time_o(now), .tick_o(tick)
  );

  acl_period_calc #(.CNT_W(CNT_W), .OUT_W(OUT_W), .NOMINAL(NOMINAL)) u_calc (
    .clk_i(clk_i), .rst_ni(rst_ni), .rise_i(rise), .tick_i(tick),
    .primed_o(primed), .res_o(res), .sat_o(sat)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cycle_o  <= '0;
      valid_o  <= 1'b0;
      zc_o     <= 1'b0;
      ts_o     <= '0;
      err_hi_o <= 1'b0;
      err_lo_o <= 1'b0;
    end else begin
      zc_o    <= rise;
      valid_o <= rise & primed;
      if (rise) ts_o <= now;
      if (rise && primed) begin
        cycle_o  <= res;
        err_hi_o <= (sat == SAT_HI);
        err_lo_o <= (sat == SAT_LO);
      end
    end
  end
endmodule

// File: rtl/acl_capture_chk.sv
module acl_capture_chk #(
  parameter int OUT_W = 16,
  parameter int TS_W  = 64
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [OUT_W-1:0] cycle_o,
  input logic             valid_o,
  input logic             zc_o,
  input logic [TS_W-1:0]  ts_o,
  input logic             err_hi_o,
  input logic             err_lo_o
);
  localparam logic [OUT_W-1:0] TOP_W = {1'b0, {(OUT_W-1){1'b1}}};
  localparam logic [OUT_W-1:0] BOT_W = {1'b1, {(OUT_W-1){1'b0}}};

  // R2
  zc_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zc_o |=> !zc_o);
  // R3
  valid_with_zc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> zc_o);
  // R5
  sat_hi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_hi_o |-> (cycle_o == TOP_W));
  // R6
  sat_lo_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_lo_o |-> (cycle_o == BOT_W));
  // R5
  flags_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(err_hi_o && err_lo_o));
  // R9
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> ($stable(cycle_o) && $stable(err_hi_o) && $stable(err_lo_o)));
  // R9
  ts_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !zc_o |-> $stable(ts_o));
  // R8
  ts_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (ts_o > $past(ts_o)));
endmodule

bind acl_capture acl_capture_chk #(.OUT_W(OUT_W), .TS_W(TS_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cycle_o(cycle_o), .valid_o(valid_o),
  .zc_o(zc_o), .ts_o(ts_o), .err_hi_o(err_hi_o), .err_lo_o(err_lo_o)
);

// File: tb/sim_acl_capture.sv
module sim_acl_capture;
  localparam int CNT_W = 12;
  localparam int OUT_W = 8;
  localparam int TS_W  = 64;
  localparam int NOM   = 200;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             wave = 1'b0;
  logic [OUT_W-1:0] cycle;
  logic             valid, zc, ehi, elo;
  logic [TS_W-1:0]  ts;

  int n_chk = 0;
  int n_bad = 0;
  int tick = 0;
  int last_r = 0;
  bit primed = 0;

  always #4 clk = ~clk;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) tick <= 0;
    else tick <= tick + 1;
  end

  acl_capture #(.CNT_W(CNT_W), .OUT_W(OUT_W), .TS_W(TS_W), .NOMINAL(NOM)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .wave_i(wave), .cycle_o(cycle),
    .valid_o(valid), .zc_o(zc), .ts_o(ts), .err_hi_o(ehi), .err_lo_o(elo)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    wave  = 1'b0;
    primed = 0;
    repeat (3) @(negedge clk);
    check(cycle == 0 && ts == 0 && !valid && !zc && !ehi && !elo, "R1",
          "outputs in reset", {cycle, ts[7:0], valid, zc, ehi, elo}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(cycle == 0 && ts == 0 && !valid && !zc && !ehi && !elo, "R1",
          "outputs after release", {cycle, ts[7:0], valid, zc, ehi, elo}, 0);
  endtask

  // one rising edge, then `total` clocks until the next one
  task automatic edge_cycle(input int total, input string req);
    int r, d, res;
    logic [OUT_W-1:0] ecyc;
    bit ehi_x, elo_x, stray;
    @(negedge clk);
    wave = 1'b1;
    r = tick;
    d = r - last_r;
    res = d - NOM;
    ehi_x = 0; elo_x = 0;
    if (res > 127) begin res = 127; ehi_x = 1; end
    else if (res < -128) begin res = -128; elo_x = 1; end
    ecyc = res[OUT_W-1:0];
    stray = 0;
    for (int i = 1; i < total; i++) begin
      @(negedge clk);
      if (i == total / 2) wave = 1'b0;
      if (i == 3) begin
        check(zc == 1'b1, "R2", "strobe after two-edge latency", zc, 1);
        check(ts == TS_W'(r + 2), "R8", "timestamp", ts, r + 2);
        if (!primed) begin
          check(valid == 1'b0, "R3", "priming edge valid", valid, 0);
        end else begin
          check(valid == 1'b1, "R3", "measurement valid", valid, 1);
          check(cycle == ecyc, req, "cycle word", $signed(cycle), res);
          check(ehi == ehi_x, (ehi_x ? "R5" : req), "high flag", ehi, ehi_x);
          check(elo == elo_x, (elo_x ? "R6" : req), "low flag", elo, elo_x);
        end
      end else if (zc) begin
        stray = 1;
      end
      if (i == total - 1 && primed) begin
        check(cycle == ecyc && !valid, "R9", "hold between strobes",
              $signed(cycle), res);
      end
    end
    check(!stray, "R10", "no strobe on falling edge or level", stray, 0);
    last_r = r;
    primed = 1;
  endtask

  initial begin
    do_reset();
    edge_cycle(200, "R3");
    edge_cycle(200, "R4");
    edge_cycle(210, "R4");
    edge_cycle(190, "R4");
    edge_cycle(327, "R4");
    edge_cycle(328, "R6");
    edge_cycle(72, "R5");
    edge_cycle(71, "R6");
    edge_cycle(500, "R6");
    edge_cycle(200, "R5");
    edge_cycle(200, "R4");
    edge_cycle(200, "R4");
    for (int k = 0; k < 20; k++) edge_cycle(230, "R7");
    edge_cycle(200, "R7");
    do_reset();
    edge_cycle(150, "R3");
    edge_cycle(150, "R4");
    edge_cycle(150, "R4");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule